// File: doc/BRIEF.md
# Sequential Non-Restoring Divider with 16.16 Mode

This block divides a 32-bit unsigned dividend by a 32-bit divisor. It produces one quotient bit per clock through a non-restoring recurrence. A pulse on `start` captures the operands and a mode bit. `busy` is high for exactly 32 cycles. `done` then pulses for one cycle, and `quotient` and `remainder` hold the result until the next accepted start.

In integer mode the dividend is the value that gets divided. In fixed-point mode the dividend and divisor are both read as 16.16 numbers. The dividend is pre-scaled by 2^16, and the quotient comes out in the same 16.16 format. The remainder register is returned exactly as the recurrence leaves it. When that value is negative (bit 31 set), adding the divisor to it gives the true remainder. The block has no trap for a divisor of zero; it runs the same recurrence.

Top module: `seq_nrdiv`

## Requirements
- R1: An accepted start, meaning `start` high while `busy` is low, sets `busy` on the next edge. In integer mode it loads the remainder register with 0 and the quotient register with the dividend.
- R2: In fixed-point mode (`fixed_mode`=1) the remainder register is loaded with dividend[31:16]. The quotient register is loaded with {dividend[15:0], 16'h0}.
- R3: Each busy cycle performs one step, with all arithmetic modulo 2^32:
  - Let s be the current remainder bit 31.
  - The remainder becomes its left shift with the quotient register's bit 31 brought in as the new bit 0.
  - The divisor is then added if s=1, or subtracted if s=0.
  - Finally the quotient register shifts left and takes the inverse of the new remainder's bit 31 as its new bit 0.
- R4: `busy` stays high for exactly 32 cycles. On the edge that ends the 32nd step, `busy` falls and `done` is high for exactly one cycle.
- R5: `start` is ignored while `busy` is high. Operands presented with it do not change the result in progress.
- R6: `quotient` and `remainder` expose the registers and hold their values while idle. The remainder receives no correction step.
- R7: For a nonzero divisor below 2^30, with no fixed-point overflow, the quotient equals the truncated quotient. The raw remainder, plus the divisor when its bit 31 is set, equals the true remainder.
- R8: A divisor of 0 has no special handling. In integer mode the result is remainder = dividend and quotient = {31 ones, ~dividend[31]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division (accepted only when idle) |
| fixed_mode | input | 1 | 1 selects 16.16 division, 0 selects integer division |
| dividend | input | 32 | Dividend, captured on an accepted start |
| divisor | input | 32 | Divisor, captured on an accepted start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse after the final step |
| quotient | output | 32 | Quotient register |
| remainder | output | 32 | Uncorrected remainder register |

## Verification
The bench aims at:
- A divisor of zero. A design that trapped or short-cut this case would return something other than the dividend as remainder.
- A start raised in the middle of a division. A design that re-armed on it would restart the count and return the quotient of the wrong operands.
- Results whose final remainder is negative. A design that quietly corrected the remainder would differ from the raw value on exactly those cases.
- Fixed-point runs. A wrong preload of the halves would produce a quotient that is off by a factor of 2^16.
- Back-to-back starts on the `done` cycle. An off-by-one step count would shift every quotient bit.

// File: rtl/seq_nrdiv.sv
module seq_nrdiv #(
  parameter int WIDTH = 32,
  parameter int FRAC  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fixed_mode,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] rem_q, quo_q, dvs_q;
  logic [CW-1:0]    step_q;
  logic             busy_q, done_q;

  logic             sgn;
  logic [WIDTH-1:0] rem_sh, rem_nx, quo_nx;
  logic [WIDTH-1:0] ld_rem, ld_quo;
  logic             accept;

  assign accept = start & ~busy_q;
  assign sgn    = rem_q[WIDTH-1];
  assign rem_sh = {rem_q[WIDTH-2:0], quo_q[WIDTH-1]};
  assign rem_nx = sgn ? rem_sh + dvs_q : rem_sh - dvs_q;
  assign quo_nx = {quo_q[WIDTH-2:0], ~rem_nx[WIDTH-1]};

  assign ld_rem = fixed_mode ? {{FRAC{1'b0}}, dividend[WIDTH-1:FRAC]} : '0;
  assign ld_quo = fixed_mode ? {dividend[FRAC-1:0], {(WIDTH-FRAC){1'b0}}} : dividend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        rem_q  <= ld_rem;
        quo_q  <= ld_quo;
        dvs_q  <= divisor;
        step_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q  <= rem_nx;
        quo_q  <= quo_nx;
        step_q <= step_q + 1'b1;
        if (step_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;
endmodule

// File: rtl/seq_nrdiv_chk.sv
module seq_nrdiv_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= 0;
    else if (start && !busy) run_len <= 0;
    else if (busy) run_len <= run_len + 1;
  end

  a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r4_step_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (run_len == WIDTH));

  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run_len < WIDTH - 1) |=> busy);

  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));
endmodule

bind seq_nrdiv seq_nrdiv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder)
);

// File: tb/sim_seq_nrdiv.sv
`timescale 1ns/1ps
module sim_seq_nrdiv;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        fixed_mode = 0;
  logic [31:0] dividend = 0;
  logic [31:0] divisor = 0;
  logic        busy, done;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  seq_nrdiv u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .fixed_mode(fixed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  // behavioural reference, 64-bit integers truncated each step
  longint unsigned m_r, m_q, m_d;
  int  m_left;
  bit  m_busy, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r = 0; m_q = 0; m_d = 0; m_left = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (start && !m_busy) begin
        m_d = divisor;
        if (fixed_mode) begin
          m_r = dividend / 65536;
          m_q = (dividend % 65536) * 65536;
        end else begin
          m_r = 0;
          m_q = dividend;
        end
        m_left = 32;
        m_busy = 1;
      end else if (m_busy) begin
        bit neg;
        neg = (m_r >= 64'h8000_0000);
        m_r = ((m_r * 2) + (m_q / 64'h8000_0000)) % 64'h1_0000_0000;
        if (neg) m_r = (m_r + m_d) % 64'h1_0000_0000;
        else     m_r = (m_r + 64'h1_0000_0000 - m_d) % 64'h1_0000_0000;
        m_q = ((m_q * 2) % 64'h1_0000_0000) + ((m_r >= 64'h8000_0000) ? 0 : 1);
        m_left = m_left - 1;
        if (m_left == 0) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R1 R2 R3 R4 R6)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 busy", busy, m_busy);
      chk("R4 done", done, m_done);
      chk("R3 quotient", quotient, m_q);
      chk("R6 remainder", remainder, m_r);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic launch(input logic [31:0] a, input logic [31:0] d, input logic fm);
    @(negedge clk);
    start = 1; dividend = a; divisor = d; fixed_mode = fm;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic check_true(input string req, input logic [31:0] d,
                            input longint unsigned num);
    longint unsigned fixr;
    fixr = remainder[31] ? ((longint'(remainder) + d) % 64'h1_0000_0000) : remainder;
    chk({req, " quotient value"}, quotient, (num / d) % 64'h1_0000_0000);
    chk({req, " corrected remainder"}, fixr, num % d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    rst_n = 1;

    launch(32'd100, 32'd7, 0); wait_done();
    check_true("R7 100/7", 7, 100);

    launch(32'd5, 32'd9, 0); wait_done();
    check_true("R7 5/9", 9, 5);
    chk("R6 raw remainder negative", remainder[31], 1);

    launch(32'hFFFF_FFFF, 32'd1, 0); wait_done();
    check_true("R7 max/1", 1, 64'hFFFF_FFFF);

    launch(32'd123456789, 32'd1000, 0); wait_done();
    check_true("R7 big", 1000, 123456789);

    // R2: fixed-point 3.0 / 2.0 = 1.5
    launch(32'h0003_0000, 32'h0002_0000, 1); wait_done();
    chk("R2 fixed 3/2", quotient, 32'h0001_8000);

    launch(32'h0001_4000, 32'h0000_3000, 1); wait_done();
    check_true("R2 fixed 1.25/0.1875", 32'h3000, 64'h0001_4000 * 65536);

    // R5: start pulse while busy with other operands
    launch(32'd1000, 32'd3, 0);
    repeat (5) @(negedge clk);
    start = 1; dividend = 32'd77; divisor = 32'd5;
    @(negedge clk);
    start = 0;
    wait_done();
    check_true("R5 ignored start", 3, 1000);

    // R8: divisor zero
    launch(32'h1234_5678, 32'd0, 0); wait_done();
    chk("R8 zero divisor remainder", remainder, 32'h1234_5678);
    chk("R8 zero divisor quotient", quotient, 32'hFFFF_FFFF);

    // back-to-back start on the done cycle
    launch(32'd50, 32'd6, 0); wait_done();
    start = 1; dividend = 32'd91; divisor = 32'd13; fixed_mode = 0;
    @(negedge clk);
    start = 0;
    chk("R1 back-to-back busy", busy, 1);
    wait_done();
    check_true("R7 back-to-back", 13, 91);

    // R6: outputs hold while idle
    repeat (10) @(negedge clk);
    check_true("R6 hold", 13, 91);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule